// File: doc/BRIEF.md
# Sticky Fault Status Capture Unit

This unit records asynchronous hardware error events for software. It keeps a 64-bit status word and a separate fault-address register. Each clock it takes a vector of error strobes, one per error class, together with the physical address, a 9-bit data ECC syndrome, a 4-bit tag ECC syndrome, the processor privilege flag and, when the error came from a bus data beat, the index of that 16-byte beat within a 64-byte transfer.

Error bits are sticky and are cleared only when software writes ones to them. The address and both syndrome fields latch the highest-priority pending error. They stay frozen until the status bit of that particular error is cleared, and from then on any new error may recapture them. A multiple-error flag marks repeats of uncorrectable and software-correctable errors. The unit drives an error pin for the protocol and internal error classes, and a trap request gated by an interrupt enable.

Top module: `fault_status_log`

## Requirements
- R1: Status bits 51:33 hold error class 0..18 (class k at bit 33+k). Once set, a bit stays set until software clears it, and further events OR into the word.
- R2: A write with `wr_en` clears exactly the status bits whose `wr_data` bit is 1, including bits 53 and 52. The address register and the syndrome fields ignore writes. A write of zero changes nothing.
- R3: The data syndrome of the captured event appears at status bits 8:0 and its tag syndrome at bits 19:16. Bits 63:54, 32:20 and 15:9 read as zero.
- R4: Bit 53 is set when an accepted event of an uncorrectable or software-correctable class arrives while that class's status bit is already set and is not cleared in the same cycle. A repeat of a hardware-corrected class never sets it.
- R5: In any cycle with an accepted event, bit 52 takes the value of `ev_priv`.
- R6: Classes 0, 1, 12, 13, 14 and 15 are bus ECC classes. A valid beat with index 0 starts a new 64-byte transfer. Once a bus ECC error has been accepted in some beat of a transfer, bus ECC strobes in the later beats of that transfer are dropped: they set no status bit, do not set bit 53 and capture nothing. Other classes are never dropped.
- R7: Priority rank: the uncorrectable classes (0-based 1, 2, 4, 6, 8, 10, 11, 12, 14, 16, 17, 18) rank above the software-correctable class 9, which ranks above the hardware-corrected classes (0, 3, 5, 7, 13, 15). Within a rank, the higher class number wins. The fields are captured when no error holds them, or when the best accepted event outranks the holder.
- R8: The fields stay frozen while the holder's status bit is set. Once that bit is cleared, they keep their value but the next accepted event captures, even if other status bits are still set.
- R9: `err_o` is high exactly while status bit 51 or bit 50 is set.
- R10: If a clear and a new event hit the same status bit in the same cycle, the bit ends up set.
- R11: `trap_o` is high exactly when `irq_en` was high in the previous cycle and at least one of bits 51:33 is set after that cycle's update.
- R12: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_strobe | input | 19 | Error-event strobe per class |
| ev_addr | input | 40 | Physical address of the event |
| ev_dsyn | input | 9 | Data ECC syndrome |
| ev_tsyn | input | 4 | Tag ECC syndrome |
| ev_priv | input | 1 | Privilege flag at detection |
| beat_vld | input | 1 | A bus data beat is present this cycle |
| beat_idx | input | 2 | 16-byte beat index within the 64-byte transfer |
| irq_en | input | 1 | Interrupt enable for the trap request |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 64 | Write-one-to-clear mask |
| status_o | output | 64 | Status word |
| fault_addr_o | output | 40 | Fault-address register |
| err_o | output | 1 | External error pin |
| trap_o | output | 1 | Trap request |

## Verification
The bench sweeps every ordered pair of error classes. This exposes an inverted or class-blind priority, since the wrong address would stay in the register. It also catches an unlock keyed to any status bit rather than the holder's own bit, since the next capture would then be lost or taken too early. Repeats of each class check that a hardware-corrected repeat does not raise the multiple-error flag. Beat sequences check that a second erring beat in a transfer is dropped, that a clean beat 0 re-arms the filter, and that non-ECC classes pass. A design that kept filtering across transfers would miss the next transfer's error. A design that let a clear beat a same-cycle event would lose the bit.

// File: rtl/fsl_pkg.sv
package fsl_pkg;
  localparam int STAT_W   = 64;
  localparam int ME_BIT   = 53;
  localparam int PRIV_BIT = 52;
  localparam int TSYN_LSB = 16;
  localparam int DSYN_LSB = 0;
  localparam int CLS_W    = 2;
endpackage

// File: rtl/fsl_txn_filter.sv
module fsl_txn_filter #(
  parameter int N_EVT = 19,
  parameter int BEAT_W = 2,
  parameter logic [N_EVT-1:0] FILT_MASK = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  strobe,
  input  logic              beat_vld,
  input  logic [BEAT_W-1:0] beat_idx,
  output logic [N_EVT-1:0]  acc,
  output logic              drop
);
  logic txn_hit;
  logic new_txn, hit_eff, ecc_now;

  always_comb begin
    new_txn = beat_vld && (beat_idx == '0);
    hit_eff = new_txn ? 1'b0 : txn_hit;
    drop    = beat_vld && hit_eff;
    acc     = strobe & ~(FILT_MASK & {N_EVT{drop}});
    ecc_now = beat_vld && |(strobe & FILT_MASK);
  end

  always_ff @(posedge clk) begin
    if (rst) txn_hit <= 1'b0;
    else if (beat_vld) txn_hit <= hit_eff | ecc_now;
  end
endmodule

// File: rtl/fsl_prio_pick.sv
module fsl_prio_pick #(
  parameter int N_EVT = 19,
  parameter logic [N_EVT-1:0] UE_MASK = '0,
  parameter logic [N_EVT-1:0] SWC_MASK = '0,
  localparam int IDX_W = $clog2(N_EVT),
  localparam int RK_W = fsl_pkg::CLS_W + IDX_W
) (
  input  logic [N_EVT-1:0] vec,
  output logic             vld,
  output logic [IDX_W-1:0] idx,
  output logic [RK_W-1:0]  rank
);
  always_comb begin
    logic [RK_W-1:0] rk_i;
    vld  = 1'b0;
    idx  = '0;
    rank = '0;
    for (int i = 0; i < N_EVT; i++) begin
      rk_i = {UE_MASK[i], ~UE_MASK[i] & SWC_MASK[i], IDX_W'(i)};
      if (vec[i] && (!vld || rk_i > rank)) begin
        vld  = 1'b1;
        idx  = IDX_W'(i);
        rank = rk_i;
      end
    end
  end
endmodule

// File: rtl/fsl_capture_lock.sv
module fsl_capture_lock #(
  parameter int N_EVT = 19,
  parameter int AW = 40,
  parameter int DSYN_W = 9,
  parameter int TSYN_W = 4,
  parameter logic [N_EVT-1:0] UE_MASK = '0,
  parameter logic [N_EVT-1:0] SWC_MASK = '0,
  localparam int IDX_W = $clog2(N_EVT),
  localparam int RK_W = fsl_pkg::CLS_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  acc,
  input  logic [N_EVT-1:0]  held,
  input  logic [AW-1:0]     ev_addr,
  input  logic [DSYN_W-1:0] ev_dsyn,
  input  logic [TSYN_W-1:0] ev_tsyn,
  output logic [AW-1:0]     addr_q,
  output logic [DSYN_W-1:0] dsyn_q,
  output logic [TSYN_W-1:0] tsyn_q
);
  logic             pick_vld;
  logic [IDX_W-1:0] pick_idx;
  logic [RK_W-1:0]  pick_rank;
  logic             lock_vld;
  logic [IDX_W-1:0] lock_idx;
  logic [RK_W-1:0]  lock_rank;
  logic             lock_eff, cap;

  fsl_prio_pick #(.N_EVT(N_EVT), .UE_MASK(UE_MASK), .SWC_MASK(SWC_MASK)) pick_i (
    .vec(acc), .vld(pick_vld), .idx(pick_idx), .rank(pick_rank)
  );

  always_comb begin
    lock_rank = {UE_MASK[lock_idx], ~UE_MASK[lock_idx] & SWC_MASK[lock_idx], lock_idx};
    lock_eff  = lock_vld && held[lock_idx];
    cap       = pick_vld && (!lock_eff || pick_rank > lock_rank);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_vld <= 1'b0;
      lock_idx <= '0;
      addr_q   <= '0;
      dsyn_q   <= '0;
      tsyn_q   <= '0;
    end else if (cap) begin
      lock_vld <= 1'b1;
      lock_idx <= pick_idx;
      addr_q   <= ev_addr;
      dsyn_q   <= ev_dsyn;
      tsyn_q   <= ev_tsyn;
    end else begin
      lock_vld <= lock_eff;
    end
  end

  // R8: without a capture the fields do not move
  assert_fields_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !cap |=> ($stable(addr_q) && $stable(dsyn_q) && $stable(tsyn_q)));
endmodule

// File: rtl/fault_status_log.sv
module fault_status_log #(
  parameter int N_EVT = 19,
  parameter int STK_LSB = 33,
  parameter int AW = 40,
  parameter int DSYN_W = 9,
  parameter int TSYN_W = 4,
  parameter int BEAT_W = 2,
  parameter int PERR_IDX = 18,
  parameter int IERR_IDX = 17,
  parameter logic [N_EVT-1:0] UE_MASK = 19'h75D56,
  parameter logic [N_EVT-1:0] SWC_MASK = 19'h00200,
  parameter logic [N_EVT-1:0] FILT_MASK = 19'h0F003
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EVT-1:0]  ev_strobe,
  input  logic [AW-1:0]     ev_addr,
  input  logic [DSYN_W-1:0] ev_dsyn,
  input  logic [TSYN_W-1:0] ev_tsyn,
  input  logic              ev_priv,
  input  logic              beat_vld,
  input  logic [BEAT_W-1:0] beat_idx,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [63:0]       wr_data,
  output logic [63:0]       status_o,
  output logic [AW-1:0]     fault_addr_o,
  output logic              err_o,
  output logic              trap_o
);
  import fsl_pkg::*;
  localparam logic [N_EVT-1:0] REP_MASK = UE_MASK | SWC_MASK;

  logic [N_EVT-1:0]  acc, st, st_next, clr, held;
  logic              drop, me, priv, me_next, priv_next;
  logic              clr_me, clr_priv;
  logic [DSYN_W-1:0] dsyn_q;
  logic [TSYN_W-1:0] tsyn_q;

  fsl_txn_filter #(.N_EVT(N_EVT), .BEAT_W(BEAT_W), .FILT_MASK(FILT_MASK)) filt_i (
    .clk(clk), .rst(rst), .strobe(ev_strobe), .beat_vld(beat_vld),
    .beat_idx(beat_idx), .acc(acc), .drop(drop)
  );

  always_comb begin
    clr      = wr_en ? wr_data[STK_LSB +: N_EVT] : '0;
    clr_me   = wr_en && wr_data[ME_BIT];
    clr_priv = wr_en && wr_data[PRIV_BIT];
    held     = st & ~clr;
    st_next  = held | acc;
    me_next  = (me & ~clr_me) | (|(acc & REP_MASK & held));
    priv_next = (|acc) ? ev_priv : (priv & ~clr_priv);
  end

  fsl_capture_lock #(.N_EVT(N_EVT), .AW(AW), .DSYN_W(DSYN_W), .TSYN_W(TSYN_W),
                     .UE_MASK(UE_MASK), .SWC_MASK(SWC_MASK)) lock_i (
    .clk(clk), .rst(rst), .acc(acc), .held(held), .ev_addr(ev_addr),
    .ev_dsyn(ev_dsyn), .ev_tsyn(ev_tsyn), .addr_q(fault_addr_o),
    .dsyn_q(dsyn_q), .tsyn_q(tsyn_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= '0;
      me     <= 1'b0;
      priv   <= 1'b0;
      err_o  <= 1'b0;
      trap_o <= 1'b0;
    end else begin
      st     <= st_next;
      me     <= me_next;
      priv   <= priv_next;
      err_o  <= st_next[PERR_IDX] | st_next[IERR_IDX];
      trap_o <= irq_en & (|st_next);
    end
  end

  always_comb begin
    status_o = '0;
    status_o[STK_LSB +: N_EVT] = st;
    status_o[ME_BIT]   = me;
    status_o[PRIV_BIT] = priv;
    status_o[TSYN_LSB +: TSYN_W] = tsyn_q;
    status_o[DSYN_LSB +: DSYN_W] = dsyn_q;
  end

  // R1: uncleared sticky bits never fall
  assert_sticky_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (held != '0) |=> ((st & $past(held)) == $past(held)));
  // R2: a cleared bit without a same-cycle event drops
  assert_w1c_R2: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((st & $past(clr & ~acc)) == '0));
  // R4: the multiple-error flag rises only on a counted repeat
  assert_me_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(me) |-> $past(|(ev_strobe & REP_MASK & st)));
  // R5: privilege follows the event
  assert_priv_capture_R5: assert property (@(posedge clk) disable iff (rst)
    (|acc) |=> (priv == $past(ev_priv)));
  // R6: a dropped beat sets no bus ECC bit
  assert_filter_drop_R6: assert property (@(posedge clk) disable iff (rst)
    drop |=> (((st & ~$past(st)) & FILT_MASK) == '0));
  // R9: error pin follows the protocol and internal bits
  assert_err_pin_R9: assert property (@(posedge clk) disable iff (rst)
    (st[PERR_IDX] | st[IERR_IDX]) |-> err_o);
  // R11: trap needs a pending sticky bit
  assert_trap_src_R11: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (st != '0));
endmodule

// File: tb/fault_status_log_tb_top.sv
module fault_status_log_tb_top;
  localparam int N = 19;
  localparam logic [N-1:0] UEM = 19'h75D56;
  localparam logic [N-1:0] SWM = 19'h00200;
  localparam logic [N-1:0] FLM = 19'h0F003;

  logic clk = 1'b0, rst = 1'b1;
  logic [N-1:0] ev_strobe = '0;
  logic [39:0] ev_addr = '0;
  logic [8:0] ev_dsyn = '0;
  logic [3:0] ev_tsyn = '0;
  logic ev_priv = 1'b0, beat_vld = 1'b0, irq_en = 1'b0, wr_en = 1'b0;
  logic [1:0] beat_idx = '0;
  logic [63:0] wr_data = '0;
  logic [63:0] status_o;
  logic [39:0] fault_addr_o;
  logic err_o, trap_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model state
  logic [N-1:0] m_st = '0;
  logic m_me = 0, m_priv = 0, m_lv = 0, m_hit = 0, m_err = 0, m_trap = 0;
  int m_li = 0;
  logic [39:0] m_addr = '0;
  logic [8:0] m_ds = '0;
  logic [3:0] m_ts = '0;

  always #5 clk = ~clk;

  fault_status_log dut_i (
    .clk(clk), .rst(rst), .ev_strobe(ev_strobe), .ev_addr(ev_addr),
    .ev_dsyn(ev_dsyn), .ev_tsyn(ev_tsyn), .ev_priv(ev_priv),
    .beat_vld(beat_vld), .beat_idx(beat_idx), .irq_en(irq_en),
    .wr_en(wr_en), .wr_data(wr_data), .status_o(status_o),
    .fault_addr_o(fault_addr_o), .err_o(err_o), .trap_o(trap_o)
  );

  function automatic int rk(int i);
    return (UEM[i] ? 64 : (SWM[i] ? 32 : 0)) + i;
  endfunction

  function automatic logic [63:0] m_word();
    logic [63:0] w = '0;
    w[51:33] = m_st; w[53] = m_me; w[52] = m_priv;
    w[19:16] = m_ts; w[8:0] = m_ds;
    return w;
  endfunction

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic cmp_all(string tag);
    chk({tag, " status"}, status_o, m_word());
    chk({tag, " addr"}, 64'(fault_addr_o), 64'(m_addr));
    chk({tag, " err R9"}, 64'(err_o), 64'(m_err));
    chk({tag, " trap R11"}, 64'(trap_o), 64'(m_trap));
  endtask

  task automatic step(string tag, logic [N-1:0] s, logic [39:0] a, logic [8:0] ds,
                      logic [3:0] ts, logic pv, logic bv, logic [1:0] bi,
                      logic ie, logic we, logic [63:0] wd);
    logic nt, he, dr, ecc, lef, cap;
    logic [N-1:0] ac, cl, hd;
    int best;
    @(negedge clk);
    ev_strobe = s; ev_addr = a; ev_dsyn = ds; ev_tsyn = ts; ev_priv = pv;
    beat_vld = bv; beat_idx = bi; irq_en = ie; wr_en = we; wr_data = wd;
    nt = bv && (bi == 2'd0);
    he = nt ? 1'b0 : m_hit;
    dr = bv && he;
    ac = dr ? (s & ~FLM) : s;
    ecc = bv && (|(s & FLM));
    cl = we ? wd[51:33] : '0;
    hd = m_st & ~cl;
    best = -1;
    for (int i = 0; i < N; i++)
      if (ac[i] && (best < 0 || rk(i) > rk(best))) best = i;
    lef = m_lv && hd[m_li];
    cap = (best >= 0) && (!lef || rk(best) > rk(m_li));
    @(posedge clk);
    if (bv) m_hit = he | ecc;
    m_me = (m_me & ~(we & wd[53])) | (|(ac & (UEM | SWM) & hd));
    m_priv = (|ac) ? pv : (m_priv & ~(we & wd[52]));
    m_st = hd | ac;
    if (cap) begin m_lv = 1; m_li = best; m_addr = a; m_ds = ds; m_ts = ts; end
    else m_lv = lef;
    m_err = m_st[18] | m_st[17];
    m_trap = ie & (|m_st);
    #1;
    cmp_all(tag);
  endtask

  task automatic idle(string tag);
    step(tag, '0, '0, '0, '0, 0, 0, 0, 0, 0, '0);
  endtask

  task automatic ev1(string tag, int k, logic [39:0] a, logic pv);
    step(tag, N'(1) << k, a, 9'(a), 4'(a >> 3), pv, 0, 0, 1, 0, '0);
  endtask

  task automatic clr(string tag, logic [63:0] wd);
    step(tag, '0, '0, 9'h1FF, 4'hF, 0, 0, 0, 1, 1, wd);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] snap;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    cmp_all("R12 reset");

    // R1 R3 R9 R11: every class alone, then its own clear
    for (int k = 0; k < N; k++) begin
      ev1("R1 single", k, 40'h1000 + 40'(k * 37), k[0]);
      chk("R3 syndrome", 64'(status_o[8:0]), 64'(9'(40'h1000 + 40'(k * 37))));
      clr("R1 clear own", 64'(1) << (33 + k));
    end

    // R7 R8 R4: all ordered pairs
    for (int a = 0; a < N; a++)
      for (int b = 0; b < N; b++) begin
        int w;
        w = (rk(b) > rk(a)) ? b : a;
        ev1("R7 first", a, 40'hA0000 + 40'(a), 1'b0);
        ev1("R7 second", b, 40'hB0000 + 40'(b), 1'b1);
        if (a == b)
          chk("R4 repeat", 64'(status_o[53]), 64'(UEM[a] | SWM[a]));
        clr("R8 clear holder", 64'(1) << (33 + w));
        ev1("R8 recapture", (a + b + 1) % N, 40'hC0000 + 40'(a * N + b), 1'b0);
        clr("R2 clear all", {64{1'b1}});
      end

    // R7 explicit: uncorrectable (class 1) overwrites hardware-corrected (class 0)
    ev1("R7", 0, 40'h111, 0);
    ev1("R7", 1, 40'h222, 0);
    chk("R7 ue over ce", 64'(fault_addr_o), 64'h222);
    // R8: clearing class 1 only unlocks even with class 0 set
    clr("R8", 64'(1) << 34);
    ev1("R8", 3, 40'h333, 0);
    chk("R8 unlock with other bit set", 64'(fault_addr_o), 64'h333);

    // R2: zero write and field writes change nothing
    snap = status_o;
    clr("R2 zero write", 64'h0);
    chk("R2 zero write no effect", status_o, snap);
    clr("R2 field write", 64'h0000_0000_000F_01FF);
    chk("R2 syndromes ignore write", status_o, snap);
    clr("R2 clear all", {64{1'b1}});
    chk("R2 all clear", 64'(status_o[53:33]), 64'h0);

    // R10: clear and event on the same bit in one cycle
    ev1("R10 set", 5, 40'h55, 0);
    step("R10 same cycle", N'(1) << 5, 40'h56, 9'h3, 4'h1, 0, 0, 0, 1, 1, 64'(1) << 38);
    chk("R10 event wins", 64'(status_o[38]), 64'h1);
    clr("R10 cleanup", {64{1'b1}});

    // R5: privilege follows latest accepted event
    ev1("R5", 3, 40'h10, 1);
    chk("R5 priv set", 64'(status_o[52]), 64'h1);
    ev1("R5", 5, 40'h11, 0);
    chk("R5 priv follows", 64'(status_o[52]), 64'h0);
    clr("R5 cleanup", {64{1'b1}});

    // R6: transfer filter
    step("R6 clean beat0", '0, '0, '0, '0, 0, 1, 0, 0, 0, '0);
    step("R6 ce beat1", N'(1), 40'h601, 9'h11, 4'h2, 0, 1, 1, 0, 0, '0);
    step("R6 ue beat2 dropped", N'(2), 40'h602, 9'h22, 4'h3, 0, 1, 2, 0, 0, '0);
    chk("R6 dropped ue", 64'(status_o[34]), 64'h0);
    chk("R6 addr not captured", 64'(fault_addr_o), 64'h601);
    step("R6 perr passes", N'(1) << 18, 40'h603, 9'h33, 4'h4, 0, 1, 3, 0, 0, '0);
    chk("R6 non ecc class kept", 64'(status_o[51]), 64'h1);
    step("R6 new txn ue", N'(2), 40'h604, 9'h44, 4'h5, 0, 1, 0, 0, 0, '0);
    chk("R6 next transfer logs", 64'(status_o[34]), 64'h1);
    step("R6 ue beat1 dropped", N'(2), 40'h605, 9'h55, 4'h6, 0, 1, 1, 0, 0, '0);
    chk("R6 drop no multi flag", 64'(status_o[53]), 64'h0);
    clr("R6 cleanup", {64{1'b1}});
    step("R6 ce beat2 fresh", N'(1), 40'h606, 9'h66, 4'h7, 0, 1, 2, 0, 0, '0);
    step("R6 ue beat3 dropped", N'(2), 40'h607, 9'h77, 4'h8, 0, 1, 3, 0, 0, '0);
    step("R6 clean beat0", '0, '0, '0, '0, 0, 1, 0, 0, 0, '0);
    step("R6 ue beat1 after clean", N'(2), 40'h608, 9'h88, 4'h9, 0, 1, 1, 0, 0, '0);
    chk("R6 rearmed", 64'(status_o[34]), 64'h1);
    clr("R6 cleanup", {64{1'b1}});

    // R11: enable gating
    step("R11 masked", N'(1) << 4, 40'h9, 9'h9, 4'h9, 0, 0, 0, 0, 0, '0);
    chk("R11 trap masked", 64'(trap_o), 64'h0);
    idle("R11 idle");
    step("R11 enabled", '0, '0, '0, '0, 0, 0, 0, 1, 0, '0);
    chk("R11 trap on", 64'(trap_o), 64'h1);
    clr("R11 clear", {64{1'b1}});
    chk("R11 trap off", 64'(trap_o), 64'h0);

    // R9 explicit
    ev1("R9", 17, 40'h17, 0);
    chk("R9 err pin", 64'(err_o), 64'h1);
    clr("R9 clear", 64'(1) << 50);
    chk("R9 err pin off", 64'(err_o), 64'h0);

    // R12: reset mid-run
    ev1("R12 pre", 1, 40'h77, 1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0;
    m_st = '0; m_me = 0; m_priv = 0; m_lv = 0; m_hit = 0; m_err = 0; m_trap = 0;
    m_addr = '0; m_ds = '0; m_ts = '0; m_li = 0;
    #1;
    cmp_all("R12 reset again");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule